// File: doc/BRIEF.md
# Dual-Channel DAC Register Bank with Armed Full Reset

This block holds the digital settings of two DAC channels. Each channel keeps a fine input register (the value software last wrote), a fine output register (the value that drives the converter), and a pair of coarse wiper registers, high and low. Writes arrive over a simple 16-bit register-write port with a 3-bit address. Reads go through a separate combinational read port.

A fine write is a write-through. The raw value is stored in the input register. On the same clock edge, the raw value plus a per-channel signed correction offset is loaded into the output register. The offset is supplied as an input port by neighbouring calibration logic. The sum is clamped to the fine range.

A software-clear word returns selected registers to their power-on values. The whole bank can also be returned to power-on state by two writes: an arm write immediately followed by a fire write.

Address map: 0 = fine channel 0 (write-through), 1 = fine channel 1 (write-through), 2 = channel 0 high wiper, 3 = channel 0 low wiper, 4 = channel 1 high wiper, 5 = channel 1 low wiper, 6 = software-clear word (write only; reads as zero).

Top module: `dac_regbank`

## Requirements
- R1: A fine write (address 0 or 1) uses only data bits 9..0. Bits 15..10 have no effect on any register.
- R2: A fine write stores the raw 10-bit value in the channel's input register. On the same edge it loads the output register with the raw value plus that channel's signed 11-bit correction. Both are visible the cycle after the write.
- R3: Reading address 0 or 1 returns the channel's raw input value, zero-extended to 16 bits. It never returns the corrected output value.
- R4: After reset, all fine input and output registers are zero, every wiper equals WIPER_POR (default 128), and the bank is not armed.
- R5: A write to addresses 2..5 loads data bits 7..0 into the addressed wiper, visible the next cycle and readable at the same address.
- R6: In the clear word (address 6), each set bit returns one register to its power-on value: bit 0 = channel 1 fine (input and output), bit 1 = channel 0 low wiper, bit 2 = channel 0 high wiper, bit 3 = channel 0 fine, bit 4 = channel 1 low wiper, bit 5 = channel 1 high wiper.
- R7: A clear word with bit 8 = 1 and bit 9 = 0 arms the bank. If the next write is a clear word with bit 9 = 1 and bit 8 = 0, every register returns to its power-on value. Idle cycles between the two writes do not disarm.
- R8: Any write other than an arm write cancels a pending arm. This includes writes to other addresses.
- R9: A fire word (bit 9 = 1, bit 8 = 0) that is not directly preceded by an arm write causes no full reset.
- R10: The corrected output is clamped to 0..1023. A negative sum gives 0 and a sum above 1023 gives 1023.
- R11: Bits 15..10, 7 and 6 of the clear word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Write address (see map) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| corr0 | input | 11 | Signed correction for channel 0 |
| corr1 | input | 11 | Signed correction for channel 1 |
| fine_out0 | output | 10 | Channel 0 fine output register |
| fine_out1 | output | 10 | Channel 1 fine output register |
| hi_wiper0 | output | 8 | Channel 0 high wiper |
| lo_wiper0 | output | 8 | Channel 0 low wiper |
| hi_wiper1 | output | 8 | Channel 1 high wiper |
| lo_wiper1 | output | 8 | Channel 1 low wiper |

## Verification
The assertions check on every cycle:
- an uncorrected write-through reaches the output unchanged;
- the read port returns the raw value after a fine write;
- an arm write sets the arm state, and any other write clears it;
- an unarmed fire word leaves every output stable;
- arm followed by fire returns the bank to power-on values.

Only the bench scenarios can show:
- the clamping values at both ends of the range;
- which clear bit maps to which register;
- that ignored bits do nothing;
- that idle cycles keep the bank armed.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_FINE0 = 3'd0,
        A_FINE1 = 3'd1,
        A_HI0   = 3'd2,
        A_LO0   = 3'd3,
        A_HI1   = 3'd4,
        A_LO1   = 3'd5,
        A_CLR   = 3'd6
    } reg_addr_e;

    localparam int NUM_CH   = 2;
    localparam int NUM_CLR  = 6;
    localparam int ARM_BIT  = 8;
    localparam int FIRE_BIT = 9;

    // Positions of the per-register clear bits in the clear word, indexed by channel.
    localparam int CLR_FINE_POS [NUM_CH] = '{3, 0};
    localparam int CLR_LO_POS   [NUM_CH] = '{1, 4};
    localparam int CLR_HI_POS   [NUM_CH] = '{2, 5};

endpackage

// File: rtl/dac_chan_regs.sv
module dac_chan_regs #(
    parameter int DATA_W    = 16,
    parameter int FINE_W    = 10,
    parameter int WIPER_W   = 8,
    parameter int CORR_W    = 11,
    parameter int WIPER_POR = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_fine,
    input  logic                     wr_hi,
    input  logic                     wr_lo,
    input  logic [DATA_W-1:0]        wr_val,
    input  logic signed [CORR_W-1:0] corr,
    input  logic                     clr_fine,
    input  logic                     clr_hi,
    input  logic                     clr_lo,
    input  logic                     full_clr,
    output logic [FINE_W-1:0]        fine_in,
    output logic [FINE_W-1:0]        fine_out,
    output logic [WIPER_W-1:0]       hi_wiper,
    output logic [WIPER_W-1:0]       lo_wiper
);

    localparam int SUM_W = ((FINE_W > CORR_W) ? FINE_W : CORR_W) + 2;
    localparam logic [SUM_W-1:0]   FINE_MAX = SUM_W'((1 << FINE_W) - 1);
    localparam logic [WIPER_W-1:0] W_POR    = WIPER_W'(WIPER_POR);

    typedef struct packed {
        logic [FINE_W-1:0]  fine_in;
        logic [FINE_W-1:0]  fine_out;
        logic [WIPER_W-1:0] hi;
        logic [WIPER_W-1:0] lo;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic [SUM_W-1:0]  sum_w;
    logic [FINE_W-1:0] sat_w;

    // Raw value plus sign-extended correction, clamped to the fine range.
    always_comb begin
        sum_w = {{(SUM_W-FINE_W){1'b0}}, wr_val[FINE_W-1:0]}
              + {{(SUM_W-CORR_W){corr[CORR_W-1]}}, corr};
        if (sum_w[SUM_W-1])
            sat_w = '0;
        else if (sum_w > FINE_MAX)
            sat_w = FINE_MAX[FINE_W-1:0];
        else
            sat_w = sum_w[FINE_W-1:0];
    end

    always_comb begin
        st_d = st_q;
        if (full_clr || clr_fine) begin
            st_d.fine_in  = '0;
            st_d.fine_out = '0;
        end else if (wr_fine) begin
            st_d.fine_in  = wr_val[FINE_W-1:0];
            st_d.fine_out = sat_w;
        end
        if (full_clr || clr_hi)
            st_d.hi = W_POR;
        else if (wr_hi)
            st_d.hi = wr_val[WIPER_W-1:0];
        if (full_clr || clr_lo)
            st_d.lo = W_POR;
        else if (wr_lo)
            st_d.lo = wr_val[WIPER_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.fine_in  <= '0;
            st_q.fine_out <= '0;
            st_q.hi       <= W_POR;
            st_q.lo       <= W_POR;
        end else begin
            st_q <= st_d;
        end
    end

    assign fine_in  = st_q.fine_in;
    assign fine_out = st_q.fine_out;
    assign hi_wiper = st_q.hi;
    assign lo_wiper = st_q.lo;

endmodule

// File: rtl/dac_swclr_ctrl.sv
module dac_swclr_ctrl #(
    parameter int DATA_W   = 16,
    parameter int NUM_CLR  = 6,
    parameter int ARM_BIT  = 8,
    parameter int FIRE_BIT = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               is_clr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [NUM_CLR-1:0] clr_bits,
    output logic               full_clr,
    output logic               armed
);

    typedef struct packed {
        logic armed;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       clr_wr, arm_word, fire_word;

    always_comb begin
        clr_wr    = wr_en && is_clr;
        arm_word  = wr_data[ARM_BIT] && !wr_data[FIRE_BIT];
        fire_word = wr_data[FIRE_BIT] && !wr_data[ARM_BIT];
        clr_bits  = clr_wr ? wr_data[NUM_CLR-1:0] : '0;
        full_clr  = clr_wr && fire_word && st_q.armed;
        st_d      = st_q;
        // Every write either re-arms (arm word) or disarms (anything else).
        if (wr_en)
            st_d.armed = clr_wr && arm_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q.armed <= 1'b0;
        else
            st_q <= st_d;
    end

    assign armed = st_q.armed;

endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
    import dac_regbank_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int FINE_W    = 10,
    parameter int WIPER_W   = 8,
    parameter int CORR_W    = 11,
    parameter int WIPER_POR = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    input  logic signed [CORR_W-1:0] corr0,
    input  logic signed [CORR_W-1:0] corr1,
    output logic [FINE_W-1:0]        fine_out0,
    output logic [FINE_W-1:0]        fine_out1,
    output logic [WIPER_W-1:0]       hi_wiper0,
    output logic [WIPER_W-1:0]       lo_wiper0,
    output logic [WIPER_W-1:0]       hi_wiper1,
    output logic [WIPER_W-1:0]       lo_wiper1
);

    logic [NUM_CLR-1:0] clr_bits;
    logic               full_clr;
    logic               armed_q;

    logic [FINE_W-1:0]        fine_in_a  [NUM_CH];
    logic [FINE_W-1:0]        fine_out_a [NUM_CH];
    logic [WIPER_W-1:0]       hi_a       [NUM_CH];
    logic [WIPER_W-1:0]       lo_a       [NUM_CH];
    logic signed [CORR_W-1:0] corr_a     [NUM_CH];

    localparam logic [ADDR_W-1:0] FINE_ADDR [NUM_CH] = '{A_FINE0, A_FINE1};
    localparam logic [ADDR_W-1:0] HI_ADDR   [NUM_CH] = '{A_HI0,   A_HI1};
    localparam logic [ADDR_W-1:0] LO_ADDR   [NUM_CH] = '{A_LO0,   A_LO1};

    assign corr_a[0] = corr0;
    assign corr_a[1] = corr1;

    dac_swclr_ctrl #(
        .DATA_W  (DATA_W),
        .NUM_CLR (NUM_CLR),
        .ARM_BIT (ARM_BIT),
        .FIRE_BIT(FIRE_BIT)
    ) u_clr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .is_clr  (wr_addr == A_CLR),
        .wr_data (wr_data),
        .clr_bits(clr_bits),
        .full_clr(full_clr),
        .armed   (armed_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dac_chan_regs #(
            .DATA_W   (DATA_W),
            .FINE_W   (FINE_W),
            .WIPER_W  (WIPER_W),
            .CORR_W   (CORR_W),
            .WIPER_POR(WIPER_POR)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_fine (wr_en && (wr_addr == FINE_ADDR[g])),
            .wr_hi   (wr_en && (wr_addr == HI_ADDR[g])),
            .wr_lo   (wr_en && (wr_addr == LO_ADDR[g])),
            .wr_val  (wr_data),
            .corr    (corr_a[g]),
            .clr_fine(clr_bits[CLR_FINE_POS[g]]),
            .clr_hi  (clr_bits[CLR_HI_POS[g]]),
            .clr_lo  (clr_bits[CLR_LO_POS[g]]),
            .full_clr(full_clr),
            .fine_in (fine_in_a[g]),
            .fine_out(fine_out_a[g]),
            .hi_wiper(hi_a[g]),
            .lo_wiper(lo_a[g])
        );
    end

    // Read port: fine addresses return the raw user value, never the corrected one.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_FINE0: rd_data = {{(DATA_W-FINE_W){1'b0}}, fine_in_a[0]};
            A_FINE1: rd_data = {{(DATA_W-FINE_W){1'b0}}, fine_in_a[1]};
            A_HI0:   rd_data = {{(DATA_W-WIPER_W){1'b0}}, hi_a[0]};
            A_LO0:   rd_data = {{(DATA_W-WIPER_W){1'b0}}, lo_a[0]};
            A_HI1:   rd_data = {{(DATA_W-WIPER_W){1'b0}}, hi_a[1]};
            A_LO1:   rd_data = {{(DATA_W-WIPER_W){1'b0}}, lo_a[1]};
            default: rd_data = '0;
        endcase
    end

    assign fine_out0 = fine_out_a[0];
    assign fine_out1 = fine_out_a[1];
    assign hi_wiper0 = hi_a[0];
    assign lo_wiper0 = lo_a[0];
    assign hi_wiper1 = hi_a[1];
    assign lo_wiper1 = lo_a[1];

endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk
    import dac_regbank_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int FINE_W    = 10,
    parameter int WIPER_W   = 8,
    parameter int CORR_W    = 11,
    parameter int WIPER_POR = 128
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [DATA_W-1:0]        wr_data,
    input logic [ADDR_W-1:0]        rd_addr,
    input logic [DATA_W-1:0]        rd_data,
    input logic signed [CORR_W-1:0] corr0,
    input logic [FINE_W-1:0]        fine_out0,
    input logic [FINE_W-1:0]        fine_out1,
    input logic [WIPER_W-1:0]       hi_wiper0,
    input logic [WIPER_W-1:0]       lo_wiper0,
    input logic [WIPER_W-1:0]       hi_wiper1,
    input logic [WIPER_W-1:0]       lo_wiper1,
    input logic                     armed_q
);

    localparam logic [WIPER_W-1:0] W_POR = WIPER_W'(WIPER_POR);

    logic arm_wr, fire_wr, at_por;
    assign arm_wr  = wr_en && wr_addr == A_CLR && wr_data[ARM_BIT] && !wr_data[FIRE_BIT];
    assign fire_wr = wr_en && wr_addr == A_CLR && wr_data[FIRE_BIT] && !wr_data[ARM_BIT];
    assign at_por  = fine_out0 == '0 && fine_out1 == '0
                  && hi_wiper0 == W_POR && lo_wiper0 == W_POR
                  && hi_wiper1 == W_POR && lo_wiper1 == W_POR;

    // R2 and R1: an uncorrected write-through carries the low data bits straight to the output.
    p_wt_nocorr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_FINE0 && corr0 == '0)
        |=> fine_out0 == $past(wr_data[FINE_W-1:0]));

    p_readback_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_FINE0)
        |=> (rd_addr != A_FINE0
             || rd_data == {{(DATA_W-FINE_W){1'b0}}, $past(wr_data[FINE_W-1:0])}));

    p_reset_state_r4: assert property (@(posedge clk)
        !rst_n |=> (at_por && !armed_q));

    p_arm_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> armed_q);

    p_full_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_wr && armed_q) |=> at_por);

    p_cancel_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !arm_wr) |=> !armed_q);

    p_no_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_wr && !armed_q && wr_data[NUM_CLR-1:0] == '0)
        |=> ($stable(fine_out0) && $stable(fine_out1) && $stable(hi_wiper0)
             && $stable(lo_wiper0) && $stable(hi_wiper1) && $stable(lo_wiper1)));

endmodule

bind dac_regbank dac_regbank_chk #(
    .DATA_W   (DATA_W),
    .FINE_W   (FINE_W),
    .WIPER_W  (WIPER_W),
    .CORR_W   (CORR_W),
    .WIPER_POR(WIPER_POR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .corr0    (corr0),
    .fine_out0(fine_out0),
    .fine_out1(fine_out1),
    .hi_wiper0(hi_wiper0),
    .lo_wiper0(lo_wiper0),
    .hi_wiper1(hi_wiper1),
    .lo_wiper1(lo_wiper1),
    .armed_q  (armed_q)
);

// File: tb/dac_regbank_tb.sv
`timescale 1ns/1ps
module dac_regbank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic signed [10:0] corr0 = '0;
    logic signed [10:0] corr1 = '0;
    logic [9:0]  fine_out0, fine_out1;
    logic [7:0]  hi_wiper0, lo_wiper0, hi_wiper1, lo_wiper1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dac_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .corr0(corr0), .corr1(corr1), .fine_out0(fine_out0), .fine_out1(fine_out1),
        .hi_wiper0(hi_wiper0), .lo_wiper0(lo_wiper0),
        .hi_wiper1(hi_wiper1), .lo_wiper1(lo_wiper1)
    );

    typedef struct packed {
        logic [15:0] data;
        logic [10:0] corr;
        logic [9:0]  exp_out;
        logic [15:0] exp_rd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{16'h0155, 11'h000, 10'h155, 16'h0155},  // R2 plain
        '{16'hFC2A, 11'h000, 10'h02A, 16'h002A},  // R1 upper bits ignored
        '{16'h0100, 11'h005, 10'h105, 16'h0100},  // R2/R3 positive corr
        '{16'h0100, 11'h7F0, 10'h0F0, 16'h0100},  // R2/R3 corr -16
        '{16'h03F0, 11'h064, 10'h3FF, 16'h03F0},  // R10 clamp high
        '{16'h0005, 11'h7EC, 10'h000, 16'h0005},  // R10 clamp low
        '{16'h03FF, 11'h3FF, 10'h3FF, 16'h03FF},  // R10 max corr
        '{16'h0000, 11'h400, 10'h000, 16'h0000}   // R10 min corr
    };

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; performs one write that is registered at the next rising edge.
    task automatic put(logic [2:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] v);
        rd_addr = a;
        #0.1;
        v = rd_data;
    endtask

    // Compares every output plus both raw fine read-backs.
    task automatic chk_all(string req, logic [9:0] f0i, logic [9:0] f0o, logic [9:0] f1i,
                           logic [9:0] f1o, logic [7:0] h0, logic [7:0] l0,
                           logic [7:0] h1, logic [7:0] l1);
        logic [15:0] v;
        rd(3'd0, v); chk({req, " fine0 raw"}, v, {6'b0, f0i});
        rd(3'd1, v); chk({req, " fine1 raw"}, v, {6'b0, f1i});
        chk({req, " fine_out0"}, {6'b0, fine_out0}, {6'b0, f0o});
        chk({req, " fine_out1"}, {6'b0, fine_out1}, {6'b0, f1o});
        chk({req, " hi0"}, {8'b0, hi_wiper0}, {8'b0, h0});
        chk({req, " lo0"}, {8'b0, lo_wiper0}, {8'b0, l0});
        chk({req, " hi1"}, {8'b0, hi_wiper1}, {8'b0, h1});
        chk({req, " lo1"}, {8'b0, lo_wiper1}, {8'b0, l1});
    endtask

    task automatic load_all();
        corr0 = 11'sd0; corr1 = 11'sd3;
        put(3'd0, 16'h0011);
        put(3'd1, 16'h0022);
        put(3'd2, 16'h00A1);
        put(3'd3, 16'h00A2);
        put(3'd4, 16'h00A3);
        put(3'd5, 16'h00A4);
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R4: reset state
        chk_all("R4", 10'h0, 10'h0, 10'h0, 10'h0, 8'd128, 8'd128, 8'd128, 8'd128);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            corr0 = VEC[i].corr;
            put(3'd0, VEC[i].data);
            chk("R2/R10 fine_out0", {6'b0, fine_out0}, {6'b0, VEC[i].exp_out});
            rd(3'd0, v);
            chk("R3/R1 raw readback", v, VEC[i].exp_rd);
        end

        // R5: wiper writes use bits 7..0
        put(3'd2, 16'hAB12);
        rd(3'd2, v); chk("R5 hi0 read", v, 16'h0012);
        chk("R5 hi0 port", {8'b0, hi_wiper0}, 16'h0012);
        put(3'd5, 16'h0177);
        chk("R5 lo1 port", {8'b0, lo_wiper1}, 16'h0077);

        // R11: ignored clear bits
        load_all();
        put(3'd6, 16'hFCC0);
        chk_all("R11", 10'h11, 10'h11, 10'h22, 10'h25, 8'hA1, 8'hA2, 8'hA3, 8'hA4);

        // R6: each clear bit in turn
        put(3'd6, 16'h0008);
        chk_all("R6 bit3", 10'h0, 10'h0, 10'h22, 10'h25, 8'hA1, 8'hA2, 8'hA3, 8'hA4);
        put(3'd6, 16'h0001);
        chk_all("R6 bit0", 10'h0, 10'h0, 10'h0, 10'h0, 8'hA1, 8'hA2, 8'hA3, 8'hA4);
        put(3'd6, 16'h0002);
        chk_all("R6 bit1", 10'h0, 10'h0, 10'h0, 10'h0, 8'hA1, 8'd128, 8'hA3, 8'hA4);
        put(3'd6, 16'h0004);
        chk_all("R6 bit2", 10'h0, 10'h0, 10'h0, 10'h0, 8'd128, 8'd128, 8'hA3, 8'hA4);
        put(3'd6, 16'h0010);
        chk_all("R6 bit4", 10'h0, 10'h0, 10'h0, 10'h0, 8'd128, 8'd128, 8'hA3, 8'd128);
        put(3'd6, 16'h0020);
        chk_all("R6 bit5", 10'h0, 10'h0, 10'h0, 10'h0, 8'd128, 8'd128, 8'd128, 8'd128);

        // R7: arm directly followed by fire
        load_all();
        put(3'd6, 16'h0100);
        put(3'd6, 16'h0200);
        chk_all("R7 direct", 10'h0, 10'h0, 10'h0, 10'h0, 8'd128, 8'd128, 8'd128, 8'd128);

        // R7: idle cycles between arm and fire keep the arm
        load_all();
        put(3'd6, 16'h0100);
        repeat (3) @(negedge clk);
        put(3'd6, 16'h0200);
        chk_all("R7 idle", 10'h0, 10'h0, 10'h0, 10'h0, 8'd128, 8'd128, 8'd128, 8'd128);

        // R8: intervening write cancels the arm
        load_all();
        put(3'd6, 16'h0100);
        put(3'd2, 16'h0044);
        put(3'd6, 16'h0200);
        chk_all("R8", 10'h11, 10'h11, 10'h22, 10'h25, 8'h44, 8'hA2, 8'hA3, 8'hA4);

        // R9: fire without arm
        put(3'd6, 16'h0200);
        chk_all("R9", 10'h11, 10'h11, 10'h22, 10'h25, 8'h44, 8'hA2, 8'hA3, 8'hA4);

        // R4: reset asserted mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_all("R4 rerst", 10'h0, 10'h0, 10'h0, 10'h0, 8'd128, 8'd128, 8'd128, 8'd128);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule